// File: doc/BRIEF.md
# External/Status Change Latch

This block watches a small set of status lines that a serial channel reports to its host: a zero-count pulse from a baud counter, a hunt-state level from the receiver, a transmit underrun/end-of-message flag, and a parameterised group of modem control lines. While the latch is open, the status word on the read port follows the lines directly. As soon as an enabled line makes a qualifying transition, the latch closes. The status word is then frozen at the values seen in that cycle, and an interrupt request goes to the host.

The host services the interrupt by reading the frozen word. It then issues the reopen command. A transition that arrives while the latch is closed is not lost. It is held as pending, and the first reopen command takes a fresh snapshot and leaves the latch closed, so the host sees the later change as well. A second reopen command then opens the latch fully. The transmit underrun flag is set by the transmitter and cleared by its own host command. Clearing it never counts as a change.

Top module: `esl_ext_status_latch`

## Requirements
- R1: After synchronous reset the latch is open, `irq_o` is 0, and `status_o` shows the live lines. The bit positions are: 0 zero count, 1 hunt, 2 transmit underrun flag, and 3 upward the modem lines in index order.
- R2: While the latch is open, every bit of `status_o` equals its live line in the same cycle.
- R3: An enabled hunt or modem line that changes in either direction closes the latch at the next clock edge. The snapshot holds the line values present at that edge.
- R4: While the latch is closed and no reopen command arrives, enabled bits of `status_o` keep their snapshot values whatever the lines do.
- R5: A line whose enable bit is 0 appears live on `status_o` at all times and never closes the latch or marks a pending change.
- R6: `irq_o` is 1 exactly when the latch is closed and `mie_i` is 1. A change with `mie_i` at 0 still closes the latch.
- R7: A reopen command with no pending change and no change in that cycle opens the latch at the next edge.
- R8: An enabled change while the latch is closed is held as pending. The next reopen command re-snapshots the lines, clears pending and keeps the latch closed. A further reopen command then opens it.
- R9: Only a rising edge of the zero-count pulse is a change. After the pulse has ended, a reopen command makes bit 0 read 0.
- R10: A `txu_set_i` pulse sets the underrun flag, and its rising edge is a change one cycle later. Clearing the flag with `txu_clr_cmd_i` raises no interrupt and closes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_pulse_i | input | 1 | Zero-count pulse from the baud counter |
| hunt_i | input | 1 | Receiver hunt-state level |
| txu_set_i | input | 1 | Transmitter underrun/end-of-message set pulse |
| txu_clr_cmd_i | input | 1 | Host command that clears the underrun flag |
| modem_i | input | NUM_MODEM | Generic modem status lines |
| src_en_i | input | NUM_SRC | Per-bit change enable, same positions as `status_o` |
| mie_i | input | 1 | Master interrupt enable |
| rst_es_cmd_i | input | 1 | Reopen command strobe, one cycle per command |
| status_o | output | NUM_SRC | Status word for the host read port |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- `irq_o` stays low whenever `mie_i` is low.
- An enabled change seen while the latch is open closes it.
- A closed latch with no reopen command keeps its snapshot unchanged.
- A reopen command opens the latch when nothing is pending.
- A reopen command with something pending keeps the latch closed and clears pending.

Some behaviour only shows up in the bench's scenarios, which compare the ports against a behavioural model in every cycle:
- The two-command reopen sequence, seen end to end.
- The rising-only treatment of the zero-count and underrun bits.
- The silent clearing of the underrun flag.
- Masked lines passing through live while other bits are frozen.

// File: rtl/esl_pkg.sv
package esl_pkg;

    // Fixed positions in the status word; modem lines follow from FIXED_SRCS up.
    localparam int ZC_IDX     = 0;
    localparam int HUNT_IDX   = 1;
    localparam int TXU_IDX    = 2;
    localparam int FIXED_SRCS = 3;

    // Which transitions of a source count as a change.
    typedef enum logic [1:0] {
        EDGE_BOTH = 2'd0,
        EDGE_RISE = 2'd1
    } edge_kind_e;

    // Latch control state.
    typedef struct packed {
        logic closed;
        logic pending;
    } latch_state_t;

    // Zero count and underrun report only their rising edge.
    function automatic edge_kind_e kind_of(input int idx);
        if (idx == ZC_IDX || idx == TXU_IDX)
            return EDGE_RISE;
        return EDGE_BOTH;
    endfunction

endpackage

// File: rtl/esl_edge_detect.sv
module esl_edge_detect
    import esl_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] live_i,
    output logic [NUM_SRC-1:0] event_o
);

    logic [NUM_SRC-1:0] prev_q;

    // The previous value tracks the lines even in reset, so no edge is seen
    // at reset release.
    always_ff @(posedge clk) begin
        prev_q <= live_i;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (kind_of(i) == EDGE_RISE) begin : g_rise
            assign event_o[i] = live_i[i] & ~prev_q[i];
        end else begin : g_both
            assign event_o[i] = live_i[i] ^ prev_q[i];
        end
    end

    logic unused_rst;
    assign unused_rst = rst;

endmodule

// File: rtl/esl_txu_flag.sv
module esl_txu_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // A set wins over a clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/esl_latch_core.sv
module esl_latch_core
    import esl_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] live_i,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic               reopen_i,
    output logic               closed_o,
    output logic               pending_o,
    output logic [NUM_SRC-1:0] snap_o
);

    latch_state_t       st_q, st_d;
    logic [NUM_SRC-1:0] snap_q, snap_d;
    logic               any_ev;

    assign any_ev = |ev_i;

    always_comb begin
        st_d   = st_q;
        snap_d = snap_q;
        if (!st_q.closed) begin
            // Transparent: the snapshot follows the lines until a change.
            snap_d = live_i;
            if (any_ev)
                st_d.closed = 1'b1;
        end else if (reopen_i) begin
            snap_d     = live_i;
            st_d.pending = 1'b0;
            // A held or simultaneous change closes the latch again at once.
            st_d.closed  = st_q.pending | any_ev;
        end else if (any_ev) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            snap_q <= '0;
        end else begin
            st_q   <= st_d;
            snap_q <= snap_d;
        end
    end

    assign closed_o  = st_q.closed;
    assign pending_o = st_q.pending;
    assign snap_o    = snap_q;

endmodule

// File: rtl/esl_ext_status_latch.sv
module esl_ext_status_latch
    import esl_pkg::*;
#(
    parameter  int NUM_MODEM = 3,
    localparam int NUM_SRC   = FIXED_SRCS + NUM_MODEM
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 zc_pulse_i,
    input  logic                 hunt_i,
    input  logic                 txu_set_i,
    input  logic                 txu_clr_cmd_i,
    input  logic [NUM_MODEM-1:0] modem_i,
    input  logic [NUM_SRC-1:0]   src_en_i,
    input  logic                 mie_i,
    input  logic                 rst_es_cmd_i,
    output logic [NUM_SRC-1:0]   status_o,
    output logic                 irq_o
);

    logic                 txu_flag;
    logic [NUM_SRC-1:0]   live_w;
    logic [NUM_SRC-1:0]   raw_ev;
    logic [NUM_SRC-1:0]   ev_en;
    logic [NUM_SRC-1:0]   snap_w;
    logic                 closed_w;
    logic                 pending_w;
    logic                 ev_any_w;

    esl_txu_flag u_txu (
        .clk    (clk),
        .rst    (rst),
        .set_i  (txu_set_i),
        .clr_i  (txu_clr_cmd_i),
        .flag_o (txu_flag)
    );

    always_comb begin
        live_w                            = '0;
        live_w[ZC_IDX]                    = zc_pulse_i;
        live_w[HUNT_IDX]                  = hunt_i;
        live_w[TXU_IDX]                   = txu_flag;
        live_w[NUM_SRC-1:FIXED_SRCS]      = modem_i;
    end

    esl_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .live_i  (live_w),
        .event_o (raw_ev)
    );

    assign ev_en    = raw_ev & src_en_i;
    assign ev_any_w = |ev_en;

    esl_latch_core #(.NUM_SRC(NUM_SRC)) u_core (
        .clk       (clk),
        .rst       (rst),
        .live_i    (live_w),
        .ev_i      (ev_en),
        .reopen_i  (rst_es_cmd_i),
        .closed_o  (closed_w),
        .pending_o (pending_w),
        .snap_o    (snap_w)
    );

    // Masked bits always pass live; enabled bits show the snapshot when closed.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_out
        assign status_o[i] = (closed_w && src_en_i[i]) ? snap_w[i] : live_w[i];
    end

    assign irq_o = closed_w & mie_i;

endmodule

// File: rtl/esl_ext_status_chk.sv
module esl_ext_status_chk #(
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               mie_i,
    input logic               irq_o,
    input logic               closed,
    input logic               pending,
    input logic [NUM_SRC-1:0] snap,
    input logic               ev_any,
    input logic               rst_es_cmd_i
);

    // R6
    irq_needs_mie_chk: assert property (@(posedge clk) disable iff (rst)
        !mie_i |-> !irq_o);

    // R3
    change_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (!closed && ev_any) |=> closed);

    // R4
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (closed && !rst_es_cmd_i) |=> (closed && $stable(snap)));

    // R7
    reopen_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (closed && rst_es_cmd_i && !pending && !ev_any) |=> !closed);

    // R8
    pending_reclose_chk: assert property (@(posedge clk) disable iff (rst)
        (closed && pending && rst_es_cmd_i && !ev_any) |=> (closed && !pending));

endmodule

bind esl_ext_status_latch esl_ext_status_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mie_i        (mie_i),
    .irq_o        (irq_o),
    .closed       (closed_w),
    .pending      (pending_w),
    .snap         (snap_w),
    .ev_any       (ev_any_w),
    .rst_es_cmd_i (rst_es_cmd_i)
);

// File: tb/esl_ext_status_latch_tb.sv
module esl_ext_status_latch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 3;
    localparam int NS = 3 + NM;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          zc = 1'b0, hunt = 1'b0, txu_set = 1'b0, txu_clr = 1'b0;
    logic [NM-1:0] modem = '0;
    logic [NS-1:0] en = '0;
    logic          mie = 1'b0, reopen = 1'b0;
    logic [NS-1:0] status;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    esl_ext_status_latch #(.NUM_MODEM(NM)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .zc_pulse_i    (zc),
        .hunt_i        (hunt),
        .txu_set_i     (txu_set),
        .txu_clr_cmd_i (txu_clr),
        .modem_i       (modem),
        .src_en_i      (en),
        .mie_i         (mie),
        .rst_es_cmd_i  (reopen),
        .status_o      (status),
        .irq_o         (irq)
    );

    // Behavioural reference model.
    bit m_closed, m_pend, m_txu;
    bit m_snap[NS];
    bit m_prev[NS];

    function automatic bit live_bit(int i);
        if (i == 0) return zc;
        if (i == 1) return hunt;
        if (i == 2) return m_txu;
        return modem[i-3];
    endfunction

    always @(posedge clk) begin
        bit cur[NS];
        int n_ev;
        n_ev = 0;
        for (int i = 0; i < NS; i++) begin
            cur[i] = live_bit(i);
            if (en[i]) begin
                if (i == 0 || i == 2) begin
                    if (cur[i] && !m_prev[i]) n_ev++;
                end else if (cur[i] != m_prev[i]) n_ev++;
            end
        end
        if (rst) begin
            m_closed = 0; m_pend = 0;
            for (int i = 0; i < NS; i++) m_snap[i] = 0;
        end else if (!m_closed) begin
            for (int i = 0; i < NS; i++) m_snap[i] = cur[i];
            if (n_ev > 0) m_closed = 1;
        end else if (reopen) begin
            for (int i = 0; i < NS; i++) m_snap[i] = cur[i];
            m_closed = m_pend || (n_ev > 0);
            m_pend = 0;
        end else if (n_ev > 0) begin
            m_pend = 1;
        end
        for (int i = 0; i < NS; i++) m_prev[i] = cur[i];
        if (rst) m_txu = 0;
        else if (txu_set) m_txu = 1;
        else if (txu_clr) m_txu = 0;
    end

    task automatic compare_all();
        logic [NS-1:0] exp_s;
        logic          exp_i;
        for (int i = 0; i < NS; i++)
            exp_s[i] = (m_closed && en[i]) ? m_snap[i] : live_bit(i);
        exp_i = m_closed && mie;
        checks += 2;
        if (status !== exp_s) begin
            errors++;
            $display("FAIL model R2 status act=%b exp=%b", status, exp_s);
        end
        if (irq !== exp_i) begin
            errors++;
            $display("FAIL model R6 irq act=%b exp=%b", irq, exp_i);
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic reopen_once();
        reopen = 1'b1;
        step();
        reopen = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 irq in reset", irq, 0);
        rst = 1'b0;
        step();
        chk("R1 irq after reset", irq, 0);
        chk("R1 status live", status, 0);
        en = '1; mie = 1'b1;
        step();

        // R2: open latch is transparent on a masked-off bit pattern
        en = '0; modem = 3'b101; #1;
        chk("R2 transparent", status, 6'b101000);
        step();
        chk("R2 no close", irq, 0);
        modem = '0; step(); en = '1; step();

        // R3 / R4 / R8: modem rise, fall while closed, two reopens
        modem[0] = 1'b1; step();
        chk("R3 close on rise", irq, 1);
        chk("R3 snap bit3", status[3], 1);
        modem[0] = 1'b0; step();
        chk("R4 frozen", status[3], 1);
        reopen_once();
        chk("R8 still closed", irq, 1);
        chk("R8 resnap bit3", status[3], 0);
        reopen_once();
        chk("R8 second opens", irq, 0);

        // R3: hunt rise then fall, each closes
        hunt = 1'b1; step();
        chk("R3 hunt rise", irq, 1);
        reopen_once();
        chk("R7 reopen", irq, 0);
        hunt = 1'b0; step();
        chk("R3 hunt fall", irq, 1);
        chk("R3 hunt snap", status[1], 0);
        reopen_once();

        // R5: masked modem[1] is live and never closes
        en = 6'b101111;
        modem[1] = 1'b1; step();
        chk("R5 masked no irq", irq, 0);
        chk("R5 masked live", status[4], 1);
        modem[0] = 1'b1; step();
        chk("R5 other closes", irq, 1);
        modem[1] = 1'b0; step();
        chk("R5 masked live closed", status[4], 0);
        reopen_once();
        chk("R5 no pending from masked", irq, 0);
        modem[0] = 1'b0; step(); reopen_once(); en = '1; step();

        // R6: mie low still closes; irq follows mie
        mie = 1'b0; modem[2] = 1'b1; step();
        chk("R6 irq masked", irq, 0);
        modem[2] = 1'b0; step();
        chk("R6 frozen while mie low", status[5], 1);
        mie = 1'b1; #1;
        chk("R6 irq with mie", irq, 1);
        step(); reopen_once(); reopen_once();
        chk("R6 reopened", irq, 0);

        // R9: zero-count pulse
        zc = 1'b1; step();
        chk("R9 zc close", irq, 1);
        chk("R9 zc snap", status[0], 1);
        zc = 1'b0; step();
        reopen_once();
        chk("R9 zc falling no pending", irq, 0);
        chk("R9 zc reads 0", status[0], 0);

        // R10: underrun set closes one cycle later; clearing is silent
        txu_set = 1'b1; step(); txu_set = 1'b0;
        chk("R10 not yet", irq, 0);
        step();
        chk("R10 close", irq, 1);
        chk("R10 snap", status[2], 1);
        reopen_once();
        chk("R10 reopen", irq, 0);
        txu_clr = 1'b1; step(); txu_clr = 1'b0;
        step(); step();
        chk("R10 clear silent", irq, 0);
        chk("R10 flag cleared", status[2], 0);

        // Simultaneous change with reopen keeps it closed (R8)
        hunt = 1'b1; step();
        hunt = 1'b0; reopen_once();
        chk("R8 change with reopen", irq, 1);
        reopen_once();
        chk("R8 final open", irq, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule